// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block is the issue controller of an in-order pipeline that issues fixed two-slot packets. Each packet is 64-bit aligned: the word at the lower address goes to the arithmetic/branch slot and the word four bytes above goes to the memory slot. The next packet starts eight bytes on. The front end delivers the packet already decoded. For each slot it supplies a valid bit, a class code, register numbers and register-use flags. The block also sees the destination and the load flag of whatever sits between decode and execute.

Every cycle the block makes one of three decisions. It can issue the whole packet. It can split the packet so that the arithmetic half goes first and the memory half follows one cycle later. Or it can hold the whole packet for one cycle behind a load whose result one of its slots needs. A slot that is empty or unusable is sent as a nop, and no later instruction ever moves into it. All results are registered. The per-cycle issue count supports instructions-per-cycle measurement.

Top module: `pair_issue_ctl`

## Requirements
- R1: A synchronous active-high reset clears the pending split state. During reset, and on the edge that samples it, every output register is loaded with 0.
- R2: The class code is 0 = ALU, 1 = branch, 2 = load, 3 = store. The arithmetic slot accepts only codes 0 and 1, and the memory slot accepts only codes 2 and 3. A valid slot holding another code is not issued, and `slotMisplaced` goes high one cycle later.
- R3: A packet with both slots valid, correctly placed and free of hazards gives `issueAluValid`, `issueMemValid` and `issueCount` = 2 one cycle later, with `fetchStall` low.
- R4: A slot whose valid bit is low is issued as a nop, and the other slot still issues on its own.
- R5: Suppose the memory slot reads, through a source whose use flag is set, the nonzero register that the arithmetic slot writes. Then the next cycle shows the arithmetic slot alone with `fetchStall` high. The cycle after that shows the memory slot alone with `fetchStall` low, taken from the held packet without a re-fetch.
- R6: If `exIsLoad` is high and any issuable slot reads `exDst` through a flagged source, nothing issues in the next cycle and `fetchStall` is high.
- R7: Register 0 never creates a hazard, either for a split or for a load-use stall.
- R8: When a load-use stall and a split both apply, the stall is taken first. The split is evaluated on the following cycle.
- R9: `issueCount` always equals the number of issue valid bits that are set.
- R10: A register match counts only when the reading source has its use flag set. A split additionally requires `aluWr` on the arithmetic slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pktValid | input | 1 | A decoded packet is present |
| aluVld | input | 1 | Arithmetic slot holds an instruction |
| aluCls | input | 2 | Arithmetic slot class code |
| aluDst | input | REG_W | Arithmetic slot destination register |
| aluSrcA | input | REG_W | Arithmetic slot first source |
| aluSrcB | input | REG_W | Arithmetic slot second source |
| aluUseA | input | 1 | Arithmetic slot reads its first source |
| aluUseB | input | 1 | Arithmetic slot reads its second source |
| aluWr | input | 1 | Arithmetic slot writes its destination |
| memVld | input | 1 | Memory slot holds an instruction |
| memCls | input | 2 | Memory slot class code |
| memSrcA | input | REG_W | Memory slot address base register |
| memSrcB | input | REG_W | Memory slot store data register |
| memUseA | input | 1 | Memory slot reads its first source |
| memUseB | input | 1 | Memory slot reads its second source |
| exDst | input | REG_W | Destination of the instruction entering execute |
| exIsLoad | input | 1 | The instruction entering execute is a load |
| issueAluValid | output | 1 | Arithmetic slot issued this cycle |
| issueMemValid | output | 1 | Memory slot issued this cycle |
| fetchStall | output | 1 | Front end must present the same packet again |
| issueCount | output | 2 | Instructions issued (0, 1 or 2) |
| slotMisplaced | output | 1 | A slot held a class its position does not accept |

## Verification
Every decision lands on the outputs at the first clock edge after the packet is presented. The bench drives inputs one time unit after an edge and samples one time unit after the next edge. A split produces two consecutive result cycles: the arithmetic half appears one edge after the packet and the memory half two edges after it. A load-use stall adds one empty result cycle before either of those. The bench follows `fetchStall` as a front end would. It keeps the packet in place, clears the load flag once the stall has drained the loaded value, and checks each successive cycle against the outcome predicted for it.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_LOAD   = 2'd2,
    CLS_STORE  = 2'd3
  } instClass_e;

  localparam int SLOTS    = 2;
  localparam int SLOT_ALU = 0;
  localparam int SLOT_MEM = 1;

  // strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic issueAlu;
    logic issueMem;
    logic hold;
    logic flagMis;
  } issueStrobe_t;

endpackage

// File: rtl/pair_hazard_dp.sv
module pair_hazard_dp
  import pair_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             pktValid,
  input  logic                             pending,
  input  logic [SLOTS-1:0]                 slotVld,
  input  logic [SLOTS-1:0][1:0]            slotCls,
  input  logic [SLOTS-1:0][REG_W-1:0]      srcA,
  input  logic [SLOTS-1:0][REG_W-1:0]      srcB,
  input  logic [SLOTS-1:0]                 useA,
  input  logic [SLOTS-1:0]                 useB,
  input  logic [REG_W-1:0]                 aluDst,
  input  logic                             aluWr,
  input  logic [REG_W-1:0]                 exDst,
  input  logic                             exIsLoad,
  input  issueStrobe_t                     strobe,
  output logic [SLOTS-1:0]                 slotOk,
  output logic                             anyBad,
  output logic                             loadUseHit,
  output logic                             intraDepHit,
  output logic                             issueAluValid,
  output logic                             issueMemValid,
  output logic                             fetchStall,
  output logic [$clog2(SLOTS+1)-1:0]       issueCount,
  output logic                             slotMisplaced
);

  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [SLOTS-1:0] slotLive;
  logic [SLOTS-1:0] slotBad;
  logic [SLOTS-1:0] exHit;

  // a flagged source matching a nonzero register
  function automatic logic readsReg(input logic [REG_W-1:0] src,
                                    input logic             useIt,
                                    input logic [REG_W-1:0] dst);
    return useIt && (dst != '0) && (src == dst);
  endfunction

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam bit WANT_MEM = (s == SLOT_MEM);
    logic isMemCls;

    assign isMemCls   = (slotCls[s] == CLS_LOAD) || (slotCls[s] == CLS_STORE);
    // the arithmetic half is already gone while a split is pending
    assign slotLive[s] = pktValid && slotVld[s] && ((s == SLOT_ALU) ? !pending : 1'b1);
    assign slotOk[s]  = slotLive[s] && (isMemCls == WANT_MEM);
    assign slotBad[s] = slotLive[s] && (isMemCls != WANT_MEM);
    assign exHit[s]   = slotOk[s] && exIsLoad &&
                        (readsReg(srcA[s], useA[s], exDst) ||
                         readsReg(srcB[s], useB[s], exDst));
  end

  assign anyBad     = |slotBad;
  assign loadUseHit = |exHit;
  assign intraDepHit = slotOk[SLOT_ALU] && slotOk[SLOT_MEM] && aluWr &&
                       (readsReg(srcA[SLOT_MEM], useA[SLOT_MEM], aluDst) ||
                        readsReg(srcB[SLOT_MEM], useB[SLOT_MEM], aluDst));

  always_ff @(posedge clk) begin
    if (rst) begin
      issueAluValid <= 1'b0;
      issueMemValid <= 1'b0;
      fetchStall    <= 1'b0;
      issueCount    <= '0;
      slotMisplaced <= 1'b0;
    end else begin
      issueAluValid <= strobe.issueAlu;
      issueMemValid <= strobe.issueMem;
      fetchStall    <= strobe.hold;
      issueCount    <= CNT_W'(strobe.issueAlu) + CNT_W'(strobe.issueMem);
      slotMisplaced <= strobe.flagMis;
    end
  end

endmodule

// File: rtl/pair_issue_fsm.sv
module pair_issue_fsm
  import pair_issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] slotOk,
  input  logic             anyBad,
  input  logic             loadUseHit,
  input  logic             intraDepHit,
  output logic             pending,
  output issueStrobe_t     strobe
);

  typedef enum logic {ST_WHOLE, ST_HELD} issueState_e;

  issueState_e state, nextState;

  always_comb begin
    strobe         = '0;
    strobe.flagMis = anyBad;
    nextState      = state;
    if (loadUseHit) begin
      // stall outranks a split; split is re-evaluated next cycle
      strobe.hold = 1'b1;
    end else if (intraDepHit) begin
      strobe.issueAlu = 1'b1;
      strobe.hold     = 1'b1;
      nextState       = ST_HELD;
    end else begin
      strobe.issueAlu = slotOk[SLOT_ALU];
      strobe.issueMem = slotOk[SLOT_MEM];
      nextState       = ST_WHOLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WHOLE;
    else     state <= nextState;
  end

  assign pending = (state == ST_HELD);

endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
  import pair_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pktValid,
  input  logic             aluVld,
  input  logic [1:0]       aluCls,
  input  logic [REG_W-1:0] aluDst,
  input  logic [REG_W-1:0] aluSrcA,
  input  logic [REG_W-1:0] aluSrcB,
  input  logic             aluUseA,
  input  logic             aluUseB,
  input  logic             aluWr,
  input  logic             memVld,
  input  logic [1:0]       memCls,
  input  logic [REG_W-1:0] memSrcA,
  input  logic [REG_W-1:0] memSrcB,
  input  logic             memUseA,
  input  logic             memUseB,
  input  logic [REG_W-1:0] exDst,
  input  logic             exIsLoad,
  output logic             issueAluValid,
  output logic             issueMemValid,
  output logic             fetchStall,
  output logic [1:0]       issueCount,
  output logic             slotMisplaced
);

  logic [SLOTS-1:0]            slotVld;
  logic [SLOTS-1:0][1:0]       slotCls;
  logic [SLOTS-1:0][REG_W-1:0] srcA;
  logic [SLOTS-1:0][REG_W-1:0] srcB;
  logic [SLOTS-1:0]            useA;
  logic [SLOTS-1:0]            useB;
  logic [SLOTS-1:0]            slotOk;
  logic                        anyBad;
  logic                        loadUseHit;
  logic                        intraDepHit;
  logic                        pending;
  issueStrobe_t                strobe;

  assign slotVld = {memVld, aluVld};
  assign slotCls = {memCls, aluCls};
  assign srcA    = {memSrcA, aluSrcA};
  assign srcB    = {memSrcB, aluSrcB};
  assign useA    = {memUseA, aluUseA};
  assign useB    = {memUseB, aluUseB};

  pair_hazard_dp #(.REG_W(REG_W)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .pktValid      (pktValid),
    .pending       (pending),
    .slotVld       (slotVld),
    .slotCls       (slotCls),
    .srcA          (srcA),
    .srcB          (srcB),
    .useA          (useA),
    .useB          (useB),
    .aluDst        (aluDst),
    .aluWr         (aluWr),
    .exDst         (exDst),
    .exIsLoad      (exIsLoad),
    .strobe        (strobe),
    .slotOk        (slotOk),
    .anyBad        (anyBad),
    .loadUseHit    (loadUseHit),
    .intraDepHit   (intraDepHit),
    .issueAluValid (issueAluValid),
    .issueMemValid (issueMemValid),
    .fetchStall    (fetchStall),
    .issueCount    (issueCount),
    .slotMisplaced (slotMisplaced)
  );

  pair_issue_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .slotOk      (slotOk),
    .anyBad      (anyBad),
    .loadUseHit  (loadUseHit),
    .intraDepHit (intraDepHit),
    .pending     (pending),
    .strobe      (strobe)
  );

endmodule

// File: rtl/pair_issue_ctl_chk.sv
module pair_issue_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pktValid,
  input logic       aluVld,
  input logic [1:0] aluCls,
  input logic       memVld,
  input logic [1:0] memCls,
  input logic       issueAluValid,
  input logic       issueMemValid,
  input logic       fetchStall,
  input logic [1:0] issueCount,
  input logic       slotMisplaced
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!issueAluValid && !issueMemValid && !fetchStall &&
             issueCount == 2'd0 && !slotMisplaced));

  // R9
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    issueCount == 2'($countones({issueAluValid, issueMemValid})));

  // R5
  split_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (fetchStall && issueAluValid) |=> !issueAluValid);

  // R6
  stall_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    fetchStall |-> !issueMemValid);

  // R2
  alu_misplace_chk: assert property (@(posedge clk) disable iff (rst)
    (pktValid && aluVld && aluCls[1]) |=> (!issueAluValid && slotMisplaced));

  // R2
  mem_misplace_chk: assert property (@(posedge clk) disable iff (rst)
    (pktValid && memVld && !memCls[1]) |=> (!issueMemValid && slotMisplaced));

endmodule

bind pair_issue_ctl pair_issue_ctl_chk u_chk (.*);

// File: tb/pair_issue_ctl_tb.sv
module pair_issue_ctl_tb;
  import pair_issue_pkg::*;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst = 1'b1;
  logic             pktValid = 1'b0;
  logic             aluVld = 1'b0, aluUseA = 1'b0, aluUseB = 1'b0, aluWr = 1'b0;
  logic [1:0]       aluCls = 2'd0, memCls = 2'd2;
  logic [REG_W-1:0] aluDst = '0, aluSrcA = '0, aluSrcB = '0;
  logic             memVld = 1'b0, memUseA = 1'b0, memUseB = 1'b0;
  logic [REG_W-1:0] memSrcA = '0, memSrcB = '0, exDst = '0;
  logic             exIsLoad = 1'b0;
  logic             issueAluValid, issueMemValid, fetchStall, slotMisplaced;
  logic [1:0]       issueCount;

  int total = 0;
  int bad = 0;
  logic modelHeld = 1'b0;
  logic nextHeld, expA, expM, expS, expMis, expLu, expDep;

  pair_issue_ctl #(.REG_W(REG_W)) u_dut (.*);

  function automatic logic rd(input logic [REG_W-1:0] s, input logic u,
                              input logic [REG_W-1:0] d);
    return u && (d != '0) && (s == d);
  endfunction

  // expected outcome of the packet now on the inputs
  task automatic predict();
    logic aOk, mOk;
    aOk    = pktValid && !modelHeld && aluVld && !aluCls[1];
    mOk    = pktValid && memVld && memCls[1];
    expMis = pktValid && ((!modelHeld && aluVld && aluCls[1]) || (memVld && !memCls[1]));
    expLu  = exIsLoad && ((aOk && (rd(aluSrcA, aluUseA, exDst) || rd(aluSrcB, aluUseB, exDst))) ||
                          (mOk && (rd(memSrcA, memUseA, exDst) || rd(memSrcB, memUseB, exDst))));
    expDep = aOk && mOk && aluWr && (rd(memSrcA, memUseA, aluDst) || rd(memSrcB, memUseB, aluDst));
    if (rst) begin
      {expA, expM, expS, expMis} = 4'b0; nextHeld = 1'b0;
    end else if (expLu) begin
      expA = 0; expM = 0; expS = 1; nextHeld = modelHeld;
    end else if (expDep) begin
      expA = 1; expM = 0; expS = 1; nextHeld = 1'b1;
    end else begin
      expA = aOk; expM = mOk; expS = 0; nextHeld = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk); #1;
    chk(tag, "issueAluValid", int'(issueAluValid), int'(expA));
    chk(tag, "issueMemValid", int'(issueMemValid), int'(expM));
    chk(tag, "fetchStall",    int'(fetchStall),    int'(expS));
    chk(tag, "slotMisplaced", int'(slotMisplaced), int'(expMis));
    chk({tag, "/R9"}, "issueCount", int'(issueCount), int'(expA) + int'(expM));
    modelHeld = nextHeld;
  endtask

  // drive one packet until it leaves, following fetchStall like a front end
  task automatic runPkt(input string tag);
    for (int k = 0; k < 4; k++) begin
      step(tag);
      if (!expS) break;
      if (expLu) exIsLoad = 1'b0;
    end
    pktValid = 1'b0;
  endtask

  task automatic setPkt(input logic aV, input logic [1:0] aC, input int aD,
                        input int aSa, input logic aUa, input logic aW,
                        input logic mV, input logic [1:0] mC,
                        input int mSa, input logic mUa, input int mSb, input logic mUb,
                        input logic exL, input int exD);
    pktValid = 1'b1;
    aluVld = aV; aluCls = aC; aluDst = REG_W'(aD);
    aluSrcA = REG_W'(aSa); aluUseA = aUa; aluSrcB = REG_W'(7); aluUseB = 1'b0; aluWr = aW;
    memVld = mV; memCls = mC;
    memSrcA = REG_W'(mSa); memUseA = mUa; memSrcB = REG_W'(mSb); memUseB = mUb;
    exIsLoad = exL; exDst = REG_W'(exD);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog run did not end actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    // R1: reset with a live packet on the inputs
    setPkt(1, CLS_ALU, 3, 1, 1, 1, 1, CLS_LOAD, 3, 1, 0, 0, 0, 0);
    step("R1"); step("R1");
    rst = 1'b0; pktValid = 1'b0;
    step("R1");

    // R3: clean pair
    setPkt(1, CLS_ALU, 3, 1, 1, 1, 1, CLS_STORE, 4, 1, 5, 1, 0, 0); runPkt("R3");
    // R4: empty slots become nops
    setPkt(0, CLS_ALU, 3, 1, 1, 1, 1, CLS_LOAD, 4, 1, 5, 0, 0, 0); runPkt("R4");
    setPkt(1, CLS_BRANCH, 0, 1, 1, 0, 0, CLS_LOAD, 4, 1, 5, 0, 0, 0); runPkt("R4");
    // R5: memory slot base depends on the arithmetic result
    setPkt(1, CLS_ALU, 6, 1, 1, 1, 1, CLS_LOAD, 6, 1, 0, 0, 0, 0); runPkt("R5");
    // R5: dependency through store data
    setPkt(1, CLS_ALU, 6, 1, 1, 1, 1, CLS_STORE, 2, 1, 6, 1, 0, 0); runPkt("R5");
    // R6: load-use on the arithmetic slot
    setPkt(1, CLS_ALU, 3, 9, 1, 1, 1, CLS_LOAD, 4, 1, 0, 0, 1, 9); runPkt("R6");
    // R7: register 0 creates no split and no stall
    setPkt(1, CLS_ALU, 0, 0, 1, 1, 1, CLS_LOAD, 0, 1, 0, 1, 1, 0); runPkt("R7");
    // R8: both hazards, stall first then split
    setPkt(1, CLS_ALU, 6, 1, 1, 1, 1, CLS_LOAD, 6, 1, 0, 0, 1, 1); runPkt("R8");
    // R10: matches without use flags or write flag do nothing
    setPkt(1, CLS_ALU, 6, 8, 0, 1, 1, CLS_LOAD, 6, 0, 8, 0, 1, 8); runPkt("R10");
    setPkt(1, CLS_ALU, 6, 1, 1, 0, 1, CLS_STORE, 6, 1, 6, 1, 0, 0); runPkt("R10");
    // R2: misplaced classes
    setPkt(1, CLS_LOAD, 3, 1, 1, 1, 1, CLS_ALU, 4, 1, 5, 0, 0, 0); runPkt("R2");
    // R9: idle cycle
    step("R9");

    // near-exhaustive sweep over classes, register matches and load flag
    for (int ac = 0; ac < 4; ac++)
      for (int mc = 0; mc < 4; mc++)
        for (int ad = 0; ad < 3; ad++)
          for (int ms = 0; ms < 3; ms++)
            for (int ed = 0; ed < 3; ed++)
              for (int el = 0; el < 2; el++)
                for (int mu = 0; mu < 2; mu++) begin
                  setPkt(1, 2'(ac), ad, 2, 1, (ac == 0), 1, 2'(mc),
                         ms, mu[0], 2, 1, el[0], ed);
                  predict();
                  if (expLu && expDep)    tag = "R8";
                  else if (expLu)         tag = "R6";
                  else if (expDep)        tag = "R5";
                  else if (expMis)        tag = "R2";
                  else if (ad == 0 || ed == 0) tag = "R7";
                  else                    tag = "R3";
                  runPkt(tag);
                end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule